// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the slave end of a three-wire serial EEPROM. It has a chip select, a serial clock, a serial data input and a serial data output. Two static straps complete the pin set: one selects the word width and one permits or blocks programming. Behind these pins sits a 16-kbit register-file array. The serial pins are brought into the system clock domain. Every command bit is sampled when a rising serial-clock edge is detected. The system clock alone drives the self-timed programming interval, so no serial-clock edges are needed while the array is being programmed.

A command opens with a start bit, which is a 1 on the data input at a rising serial-clock edge while the part is selected and idle. Two opcode bits follow. Next comes an address that is 10 bits long in 16-bit mode and 11 bits long in 8-bit mode. Write-type commands then carry data. All fields are sent MSB first. The state machine uses these states: `ST_IDLE`, `ST_OPCODE`, `ST_ADDR`, `ST_DATA`, `ST_READ`, `ST_PROG`, `ST_STATUS` and `ST_DONE`.

Transitions:
- IDLE→OPCODE on a start bit.
- OPCODE→ADDR after two bits.
- ADDR→READ, ADDR→DATA, ADDR→PROG or ADDR→DONE when the address is complete, depending on the opcode.
- DATA→PROG or DATA→DONE when the data is complete.
- PROG→STATUS, or PROG→IDLE if deselected, when the timer expires.
- STATUS→OPCODE on a start bit.
- Any state except PROG →IDLE while deselected.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is low, every state except ST_PROG returns to ST_IDLE and dout is 0.
- R2: In ST_IDLE, rising serial-clock edges with data input 0 leave the state unchanged. A start bit is data input 1 sampled on a rising edge while selected.
- R3: Opcode 10 reads, 01 writes and 11 erases one location. Opcode 00 is a special command chosen by the two top address bits: 11 enables programming, 00 disables it, 10 erases the whole array, and 01 writes the data word to every location. The address is 10 bits in 16-bit mode (org=1) and 11 bits in 8-bit mode (org=0).
- R4: A read drives a 0 on dout after the last address bit. Each following rising edge then presents the next data bit, MSB first.
- R5: If clocking continues with chip select high, a read goes straight on to the next address with no extra 0 bit. The address wraps from the top of the array to 0.
- R6: In 8-bit mode, address bits [10:1] pick the 16-bit word and bit 0 picks the byte within it: 1 selects the upper byte and 0 the lower byte.
- R7: After reset, programming is disabled, and write and erase commands leave the array untouched until the enable command is received. The disable command blocks them again.
- R8: With pe low, no write, erase, erase-all or write-all changes the array, and no programming interval starts.
- R9: A programming interval lasts PROG_CYCLES system clocks, and dout is 0 throughout it. The interval completes even if chip select falls or the serial clock stops.
- R10: When programming ends with chip select high, dout reads 1 until the next start bit.
- R11: Erase sets the addressed location to all ones. Erase-all sets every word to all ones. Write-all writes the data to every word, and in 8-bit mode it writes the byte into both halves.
- R12: Once a command has completed without a read or a programming interval, further clock and data activity is ignored until chip select goes low.
- R13: After reset, every word reads as FFFF and dout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| di | input | 1 | Serial data input |
| org | input | 1 | Width strap: 1 selects 16-bit words, 0 selects 8-bit words |
| pe | input | 1 | Programming permit strap, active high |
| dout | output | 1 | Serial data output and ready/busy status |

## Verification
Several behaviours are checked by assertions on every cycle. Deselection forces the machine back to idle outside a programming interval. Idle ignores clock edges that carry no start bit. A programming interval cannot begin while the strap forbids it or while programming is disabled. The timer counts down without stalling, and the end of an interval leads to the status display. An erase-all or write-all is seen to reach the last word. Other behaviours can only be shown by the bench's scenarios, because they depend on whole bit streams. These cover the dummy bit and MSB-first order of reads, sequential streaming across the wrap point, byte-lane placement in 8-bit mode, that a completed command cannot be extended with extra bits, and that data written in one command reads back later.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_PROG,
        ST_STATUS,
        ST_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        SP_LOCK   = 2'b00,
        SP_FILL   = 2'b01,
        SP_WIPE   = 2'b10,
        SP_UNLOCK = 2'b11
    } mw_special_e;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sclk_rise
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] chain_q [STAGES];
    logic            sclk_s;
    logic            sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            chain_q[0] <= {cs, sclk, di};
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            sclk_prev_q <= sclk_s;
        end
    end

    assign {cs_s, sclk_s, di_s} = chain_q[STAGES-1];
    assign sclk_rise = cs_s & sclk_s & ~sclk_prev_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               left_q <= '0;
        else if (start)           left_q <= CW'(CYCLES);
        else if (left_q != '0)    left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    // R9: a launched interval is busy on the next cycle
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R9: the interval advances every system clock, with no serial clock needed
    a_r9_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start |=> left_q < $past(left_q));
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          we_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] wmask,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_word
            logic [DW-1:0] cell_q;
            logic          hit;
            assign hit = we && (we_all || waddr == AW'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   cell_q <= '1;
                else if (hit) cell_q <= (cell_q & ~wmask) | (wdata & wmask);
            end
            assign words[g] = cell_q;
        end
    endgenerate

    assign rdata = words[raddr];

    // R11: a full-width write to every word reaches the last word
    a_r11_fill_reaches_end: assert property (@(posedge clk) disable iff (!rst_n)
        we && we_all && wmask == '1 |=> words[DEPTH-1] == $past(wdata));
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_eeprom_pkg::*;
#(
    parameter int WORD_AW     = 10,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    input  logic org,
    input  logic pe,
    output logic dout
);
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int MAXLEN  = (BYTE_AW > WORD_W) ? BYTE_AW : WORD_W;
    localparam int CNT_W   = $clog2(MAXLEN + 1);

    // synchronised pins
    logic cs_s, di_s, rise;

    mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sclk_rise(rise)
    );

    // state and datapath registers
    mw_state_e           state_q, state_d;
    mw_op_e              op_q, op_d;
    logic [BYTE_AW-1:0]  addr_q, addr_d;
    logic [WORD_W-2:0]   data_q, data_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [WORD_W-1:0]   rd_q, rd_d;
    logic                out_q, out_d;
    logic                wen_q, wen_d;

    // derived fields
    logic [BYTE_AW-1:0]  addr_nx, addr_inc, rsel;
    logic [WORD_W-1:0]   data_nx;
    logic [CNT_W-1:0]    alen_m1, dlen, dlen_m1;
    mw_special_e         sp_code;

    // array interface
    logic                arr_we, prog_busy;
    logic [WORD_AW-1:0]  arr_raddr, arr_waddr;
    logic [WORD_W-1:0]   arr_rdata, arr_wdata, arr_wmask, rd_load;
    logic [BYTE_W-1:0]   rd_byte;

    // programming command from the next-state logic
    logic                go, go_all;
    logic [BYTE_AW-1:0]  go_addr;
    logic [WORD_W-1:0]   go_fill;

    assign addr_nx = {addr_q[BYTE_AW-2:0], di_s};
    assign data_nx = {data_q, di_s};
    assign alen_m1 = org ? CNT_W'(WORD_AW - 1) : CNT_W'(BYTE_AW - 1);
    assign dlen    = org ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
    assign dlen_m1 = dlen - 1'b1;
    assign sp_code = mw_special_e'(org ? addr_nx[WORD_AW-1 -: 2] : addr_nx[BYTE_AW-1 -: 2]);

    always_comb begin
        addr_inc = addr_q + 1'b1;
        if (org) addr_inc[BYTE_AW-1] = 1'b0;
    end

    // read path: the next word during streaming, the addressed word otherwise
    assign rsel      = (state_q == ST_READ) ? addr_inc : addr_nx;
    assign arr_raddr = org ? rsel[WORD_AW-1:0] : rsel[BYTE_AW-1:1];
    assign rd_byte   = rsel[0] ? arr_rdata[WORD_W-1:BYTE_W] : arr_rdata[BYTE_W-1:0];
    assign rd_load   = org ? arr_rdata : {rd_byte, {BYTE_W{1'b0}}};

    // write path
    assign arr_waddr = org ? go_addr[WORD_AW-1:0] : go_addr[BYTE_AW-1:1];
    assign arr_wdata = org ? go_fill : {go_fill[BYTE_W-1:0], go_fill[BYTE_W-1:0]};
    assign arr_wmask = (org || go_all) ? '1 :
                       (go_addr[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                                   : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}});
    assign arr_we    = go && wen_q && pe;

    mw_word_array #(.AW(WORD_AW), .DW(WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .we_all(go_all),
        .waddr(arr_waddr), .wdata(arr_wdata), .wmask(arr_wmask),
        .raddr(arr_raddr), .rdata(arr_rdata)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(arr_we), .busy(prog_busy)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_SPECIAL;
            addr_q  <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
            rd_q    <= '0;
            out_q   <= 1'b0;
            wen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            cnt_q   <= cnt_d;
            rd_q    <= rd_d;
            out_q   <= out_d;
            wen_q   <= wen_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        addr_d  = addr_q;
        data_d  = data_q;
        cnt_d   = cnt_q;
        rd_d    = rd_q;
        out_d   = out_q;
        wen_d   = wen_q;
        go      = 1'b0;
        go_all  = 1'b0;
        go_addr = addr_q;
        go_fill = '1;

        if (!cs_s && state_q != ST_PROG) begin
            state_d = ST_IDLE;
            out_d   = 1'b0;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_STATUS: begin
                    if (rise && di_s) begin
                        state_d = ST_OPCODE;
                        cnt_d   = '0;
                    end
                end
                ST_OPCODE: begin
                    if (rise) begin
                        op_d = mw_op_e'({op_q[0], di_s});
                        if (cnt_q == CNT_W'(1)) begin
                            state_d = ST_ADDR;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        addr_d = addr_nx;
                        cnt_d  = cnt_q + 1'b1;
                        if (cnt_q == alen_m1) begin
                            cnt_d = '0;
                            unique case (op_q)
                                OP_READ: begin
                                    state_d = ST_READ;
                                    out_d   = 1'b0;
                                    rd_d    = rd_load;
                                    cnt_d   = dlen;
                                end
                                OP_WRITE: state_d = ST_DATA;
                                OP_ERASE: begin
                                    go      = 1'b1;
                                    go_addr = addr_nx;
                                end
                                OP_SPECIAL: begin
                                    unique case (sp_code)
                                        SP_UNLOCK: begin wen_d = 1'b1; state_d = ST_DONE; end
                                        SP_LOCK:   begin wen_d = 1'b0; state_d = ST_DONE; end
                                        SP_WIPE:   begin go = 1'b1; go_all = 1'b1; end
                                        SP_FILL:   state_d = ST_DATA;
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    if (rise) begin
                        data_d = data_nx[WORD_W-2:0];
                        cnt_d  = cnt_q + 1'b1;
                        if (cnt_q == dlen_m1) begin
                            go      = 1'b1;
                            go_all  = (op_q == OP_SPECIAL);
                            go_fill = data_nx;
                        end
                    end
                end
                ST_READ: begin
                    if (rise) begin
                        if (cnt_q == '0) begin
                            addr_d = addr_inc;
                            out_d  = rd_load[WORD_W-1];
                            rd_d   = rd_load << 1;
                            cnt_d  = dlen_m1;
                        end else begin
                            out_d = rd_q[WORD_W-1];
                            rd_d  = rd_q << 1;
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (!prog_busy) state_d = cs_s ? ST_STATUS : ST_IDLE;
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
            endcase
            if (go) state_d = (wen_q && pe) ? ST_PROG : ST_DONE;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_READ:   dout = out_q;
            ST_STATUS: dout = 1'b1;
            default:   dout = 1'b0;
        endcase
    end

    // R1: deselection returns every non-programming state to idle
    a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s && state_q != ST_PROG |=> state_q == ST_IDLE);
    // R2: idle ignores edges that carry no start bit
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && cs_s && !(rise && di_s) |=> state_q == ST_IDLE);
    // R7: no programming interval while programming is disabled
    a_r7_locked_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_q && state_q != ST_PROG |=> state_q != ST_PROG);
    // R8: no programming interval while the permit strap is low
    a_r8_strap_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !pe && state_q != ST_PROG |=> state_q != ST_PROG);
    // R9: the interval holds until the timer expires, whatever chip select does
    a_r9_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PROG && prog_busy |=> state_q == ST_PROG);
    // R10: a finished interval with chip select high shows ready
    a_r10_ready_shown: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PROG && !prog_busy && cs_s |=> dout);
endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
    localparam int PROG  = 40;
    localparam int HP    = 4;
    localparam int LIMIT = PROG + 60;

    typedef struct packed {
        logic [9:0]  a;
        logic [15:0] d;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{10'd0,    16'hA55A},
        '{10'd1,    16'h0001},
        '{10'd1023, 16'h8000},
        '{10'd512,  16'h0000},
        '{10'd77,   16'h1234},
        '{10'd300,  16'hC3C3}
    };

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
    logic dout;
    int n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .org(org), .pe(pe), .dout(dout)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        di = b; tick(HP); sclk = 1'b1; tick(HP); sclk = 1'b0;
    endtask

    task automatic shift(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    function automatic int alen();
        return org ? 10 : 11;
    endfunction

    function automatic int dlen();
        return org ? 16 : 8;
    endfunction

    task automatic begin_cmd(input logic [1:0] op);
        cs = 1'b1; tick(HP); pulse(1'b1); shift({30'd0, op}, 2);
    endtask

    task automatic end_cmd();
        cs = 1'b0; di = 1'b0; tick(3 * HP);
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (dout !== 1'b1 && cyc < LIMIT) begin tick(1); cyc++; end
    endtask

    task automatic do_write(input logic [10:0] a, input logic [15:0] d, output int cyc);
        begin_cmd(2'b01); shift({21'd0, a}, alen()); shift({16'd0, d}, dlen());
        wait_ready(cyc); end_cmd();
    endtask

    task automatic do_erase(input logic [10:0] a, output int cyc);
        begin_cmd(2'b11); shift({21'd0, a}, alen()); wait_ready(cyc); end_cmd();
    endtask

    task automatic do_special(input logic [1:0] code, input logic [15:0] d, output int cyc);
        begin_cmd(2'b00);
        shift({30'd0, code} << (alen() - 2), alen());
        if (code == 2'b01) shift({16'd0, d}, dlen());
        if (code == 2'b01 || code == 2'b10) wait_ready(cyc); else cyc = 0;
        end_cmd();
    endtask

    task automatic do_read(input logic [10:0] a, input int nbits, output logic [31:0] v, output logic dummy);
        begin_cmd(2'b10); shift({21'd0, a}, alen());
        dummy = dout; v = '0;
        for (int i = 0; i < nbits; i++) begin pulse(1'b0); v = {v[30:0], dout}; end
        end_cmd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c;
        logic [31:0] v;
        logic dm;

        tick(5); rst_n = 1'b1; tick(5);
        // R13: reset state
        check("R13 dout after reset", {31'd0, dout}, 32'd0);
        do_read(11'd5, 16, v, dm);
        check("R13 erased word after reset", v, 32'h0000FFFF);
        check("R4 dummy bit", {31'd0, dm}, 32'd0);

        // R7: locked after reset
        do_write(11'd3, 16'h1234, c);
        check("R7 no status while locked", c, LIMIT);
        do_read(11'd3, 16, v, dm);
        check("R7 locked write ignored", v, 32'h0000FFFF);

        do_special(2'b11, 16'h0, c);

        // R3/R4/R9: vector table walk
        foreach (VECS[i]) begin
            do_write({1'b0, VECS[i].a}, VECS[i].d, c);
            check("R9 programming length", {31'd0, (c >= PROG - 6 && c <= PROG + 4)}, 32'd1);
            do_read({1'b0, VECS[i].a}, 16, v, dm);
            check("R3 R4 write then read", v, {16'd0, VECS[i].d});
        end

        // R5: sequential read and wrap
        do_read(11'd0, 32, v, dm);
        check("R5 sequential read", v, 32'hA55A0001);
        do_read(11'd1023, 32, v, dm);
        check("R5 wrap to zero", v, 32'h8000A55A);

        // R2: idle clocks without a start bit
        cs = 1'b1; tick(HP);
        repeat (6) pulse(1'b0);
        pulse(1'b1); shift(32'b10, 2); shift(32'd77, 10);
        v = '0;
        for (int i = 0; i < 16; i++) begin pulse(1'b0); v = {v[30:0], dout}; end
        end_cmd();
        check("R2 idle edges ignored", v, 32'h00001234);

        // R12: extra bits after a completed command
        begin_cmd(2'b00); shift(32'h300, 10);
        pulse(1'b1); shift(32'b01, 2); shift(32'd41, 10); shift(32'hDEAD, 16);
        tick(LIMIT);
        check("R12 no status after extra bits", {31'd0, dout}, 32'd0);
        end_cmd();
        do_read(11'd41, 16, v, dm);
        check("R12 extra bits ignored", v, 32'h0000FFFF);

        // R10: ready held until the next start bit
        begin_cmd(2'b01); shift(32'd40, 10); shift(32'h0F0F, 16);
        wait_ready(c); tick(50);
        check("R10 ready held", {31'd0, dout}, 32'd1);
        pulse(1'b1);
        check("R10 start bit clears ready", {31'd0, dout}, 32'd0);
        end_cmd();

        // R9: deselect during programming
        begin_cmd(2'b01); shift(32'd7, 10); shift(32'hA5A5, 16);
        cs = 1'b0;
        repeat (3) pulse(1'b1);
        tick(PROG + 20);
        do_read(11'd7, 16, v, dm);
        check("R9 completes after deselect", v, 32'h0000A5A5);

        // R8: permit strap low
        pe = 1'b0;
        do_write(11'd8, 16'h5555, c);
        check("R8 no busy with strap low", c, LIMIT);
        do_special(2'b10, 16'h0, c);
        pe = 1'b1;
        do_read(11'd8, 16, v, dm);
        check("R8 write blocked", v, 32'h0000FFFF);
        do_read(11'd0, 16, v, dm);
        check("R8 erase-all blocked", v, 32'h0000A55A);

        // R11: erase, write-all, erase-all
        do_erase(11'd0, c);
        do_read(11'd0, 16, v, dm);
        check("R11 erase one", v, 32'h0000FFFF);
        do_special(2'b01, 16'h0F0F, c);
        do_read(11'd500, 16, v, dm);
        check("R11 write-all", v, 32'h00000F0F);
        do_read(11'd1023, 16, v, dm);
        check("R11 write-all last", v, 32'h00000F0F);
        do_special(2'b10, 16'h0, c);
        do_read(11'd500, 16, v, dm);
        check("R11 erase-all", v, 32'h0000FFFF);

        // R6: 8-bit mode lanes
        org = 1'b0; tick(4);
        do_write(11'd21, 16'h003C, c);
        do_read(11'd21, 8, v, dm);
        check("R6 upper byte", v, 32'h0000003C);
        do_read(11'd20, 16, v, dm);
        check("R6 byte stream", v, 32'h0000FF3C);
        org = 1'b1; tick(4);
        do_read(11'd10, 16, v, dm);
        check("R6 word view", v, 32'h00003CFF);

        // R7: disable command
        do_special(2'b00, 16'h0, c);
        do_write(11'd9, 16'h1111, c);
        do_read(11'd9, 16, v, dm);
        check("R7 disabled write ignored", v, 32'h0000FFFF);

        // R13/R1: reset mid-run
        cs = 1'b1; tick(HP);
        check("R1 selected idle dout", {31'd0, dout}, 32'd0);
        cs = 1'b0;
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
        do_read(11'd40, 16, v, dm);
        check("R13 array cleared by reset", v, 32'h0000FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule